// File: doc/BRIEF.md
# Motor Fault Latch and Retry Manager

This block sits between the protection comparators of a three-phase motor power stage and the gate-driver enable. Each of eight fault inputs is a level from a monitor. The block turns these levels into a single driver-disable signal and decides how each fault recovers. Overcurrent and FET-short trips hold the drivers off for a fixed retry time. Supply and thermal faults release as soon as their condition is gone. A locked-rotor trip waits eight lock-timer periods. The overcurrent, FET-short and locked-rotor faults can instead be set to latch. A latched fault holds the drivers off until one of four clearing events occurs.

Two sticky 8-bit status registers record which faults and which warnings have occurred. Both clear on read, but only for bits whose condition has gone away. A diagnostic pin shows whether a fault or an unblanked warning is active. Its polarity is selectable. An option restricts the pin to latched faults only. All delays are counted in system clocks. The defaults assume a 10 MHz clock: 52.4 ms for the short retry and 420 ms per lock-timer period.

Top module: `fault_retry_mgr`

## Requirements
- R1: Overcurrent (fault bit 0) and FET short (bit 5) are timed faults. When not latched, a condition seen at a clock edge raises `drv_off` at the next edge. `drv_off` then falls exactly RETRY_CYCLES edges after it rose, even if the condition is still present. A condition still present after that re-trips the fault.
- R2: Supply undervoltage (bit 1), supply overvoltage (bit 2), high-side pump undervoltage (bit 3), low-side gate supply undervoltage (bit 4) and external overtemperature (bit 6) are level faults. `drv_off` follows the condition with a two-edge lag and never latches.
- R3: Locked rotor (bit 7), when not latched, holds `drv_off` for 8×LOCK_CYCLES edges after it rises.
- R4: `latch_en[0]`, `latch_en[1]` and `latch_en[2]` make bits 0, 5 and 7 latch. A latched fault keeps `drv_off` high for as long as no clearing event occurs.
- R5: A latch is cleared by any of four events: `rst_n` low, `en` low, `low_duty_off` high, or `rst_wr_valid` with `rst_wr_data` equal to 8'hFF. A write with any other data has no effect. After a clear, `drv_off` falls at the next edge if nothing else holds it.
- R6: `en` low forces `drv_off` high at the next edge. Reset also sets `drv_off` high.
- R7: `err_status[i]` is set when `fault_lvl[i]` is high and `fault_mask[i]` is low. A masked fault sets no status bit and does not raise `drv_off`. The bit order is the same as the fault bit numbering in R1–R3.
- R8: `err_rd`, or any clearing event of R5, clears the `err_status` bits whose qualified condition is low in that cycle. A bit whose condition is present in the same cycle stays set.
- R9: `warn_status[i]` is set while `warn_lvl[i]` is high and clears on `warn_rd` or a clearing event once the warning is gone. Warnings never raise `drv_off`.
- R10: The diagnostic is active while any fault is holding the drivers off, or while any warning with a low `warn_blank` bit is present. With `diag_pol` = 1 the active pin level is 1. With `diag_pol` = 0 the active level is 0.
- R11: With `diag_latch_only` = 1, only a latched fault makes the diagnostic active. Unlatched faults and warnings still appear in the status registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, acts as power-on clear |
| en | input | 1 | Motor stage enable level |
| fault_lvl | input | 8 | Fault condition levels, bit order as R7 |
| fault_mask | input | 8 | 1 = ignore that fault |
| latch_en | input | 3 | Latch enables for overcurrent, FET short, locked rotor |
| warn_lvl | input | NWARN | Warning condition levels |
| warn_blank | input | NWARN | 1 = warning does not drive the diagnostic |
| diag_pol | input | 1 | Diagnostic active level |
| diag_latch_only | input | 1 | Diagnostic shows latched faults only |
| low_duty_off | input | 1 | Input duty below the off threshold |
| rst_wr_valid | input | 1 | One-cycle strobe of a write to the fault reset register |
| rst_wr_data | input | 8 | Data of that write |
| err_rd | input | 1 | Read strobe of the error status |
| warn_rd | input | 1 | Read strobe of the warning status |
| drv_off | output | 1 | 1 = gate drivers disabled |
| err_status | output | 8 | Sticky fault status |
| warn_status | output | NWARN | Sticky warning status |
| diag_pin | output | 1 | Diagnostic level |

## Verification
A status read can land in the same cycle that a fault condition arrives or is still present. In that case the set must win over the clear-on-read. A random phase drives level faults and warnings together with random read strobes, and compares both registers against a bench model every cycle. A second collision pairs a clearing event with a latched fault. Directed cases issue each of the four clear events against a latched trip and check the cycle in which `drv_off` drops, and that a reset-register write with the wrong data is ignored.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int NFAULT    = 8;
  localparam int FLT_OC    = 0;
  localparam int FLT_SHORT = 5;
  localparam int FLT_LOCK  = 7;

  localparam int REC_LEVEL = 0;
  localparam int REC_TIMED = 1;

  function automatic int recov_of(input int idx);
    if (idx == FLT_OC || idx == FLT_SHORT || idx == FLT_LOCK) return REC_TIMED;
    return REC_LEVEL;
  endfunction
endpackage

// File: rtl/frm_fault_chan.sv
module frm_fault_chan #(
  parameter int RECOV = 0,
  parameter int DELAY = 4,
  localparam int CW   = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic latch_en,
  input  logic clr,
  output logic inhibit,
  output logic latched
);
  if (RECOV == frm_pkg::REC_LEVEL) begin : g_level
    logic unused_in;
    assign unused_in = latch_en ^ clr;
    assign latched   = 1'b0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inhibit <= 1'b0;
      else        inhibit <= cond;
    end
  end else begin : g_timed
    logic [CW-1:0] tmr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inhibit <= 1'b0;
        latched <= 1'b0;
        tmr     <= '0;
      end else if (latched) begin
        if (clr) begin
          latched <= 1'b0;
          inhibit <= 1'b0;
        end
      end else if (inhibit) begin
        if (tmr == '0) inhibit <= 1'b0;
        else           tmr <= tmr - 1'b1;
      end else if (cond) begin
        inhibit <= 1'b1;
        latched <= latch_en;
        tmr     <= CW'(DELAY - 1);
      end
    end
  end
endmodule

// File: rtl/frm_sticky.sv
module frm_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         wipe,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (wipe) q <= set;
    else           q <= q | set;
  end
endmodule

// File: rtl/frm_diag_out.sv
module frm_diag_out #(
  parameter int NF = 8,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pol,
  input  logic          latch_only,
  input  logic [NF-1:0] inhibit,
  input  logic [NF-1:0] latched,
  input  logic [NW-1:0] warn,
  input  logic [NW-1:0] blank,
  output logic          pin
);
  logic act_q;
  logic act_d;

  always_comb begin
    if (latch_only) act_d = |latched;
    else            act_d = (|inhibit) | (|(warn & ~blank));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign pin = pol ? act_q : ~act_q;
endmodule

// File: rtl/fault_retry_mgr.sv
module fault_retry_mgr #(
  parameter int NWARN        = 8,
  parameter int RETRY_CYCLES = 524000,
  parameter int LOCK_CYCLES  = 4200000,
  parameter logic [7:0] RST_KEY = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [7:0]       fault_lvl,
  input  logic [7:0]       fault_mask,
  input  logic [2:0]       latch_en,
  input  logic [NWARN-1:0] warn_lvl,
  input  logic [NWARN-1:0] warn_blank,
  input  logic             diag_pol,
  input  logic             diag_latch_only,
  input  logic             low_duty_off,
  input  logic             rst_wr_valid,
  input  logic [7:0]       rst_wr_data,
  input  logic             err_rd,
  input  logic             warn_rd,
  output logic             drv_off,
  output logic [7:0]       err_status,
  output logic [NWARN-1:0] warn_status,
  output logic             diag_pin
);
  import frm_pkg::*;

  localparam int LOCK_DELAY = 8 * LOCK_CYCLES;

  logic [NFAULT-1:0] qual;
  logic [NFAULT-1:0] latch_map;
  logic [NFAULT-1:0] inhibit_vec;
  logic [NFAULT-1:0] latched_vec;
  logic              clr_evt;

  assign qual      = fault_lvl & ~fault_mask;
  assign latch_map = {latch_en[2], 1'b0, latch_en[1], 4'b0000, latch_en[0]};
  assign clr_evt   = ~en | low_duty_off | (rst_wr_valid && rst_wr_data == RST_KEY);

  for (genvar i = 0; i < NFAULT; i++) begin : g_ch
    localparam int REC = recov_of(i);
    localparam int DLY = (i == FLT_LOCK) ? LOCK_DELAY : RETRY_CYCLES;
    frm_fault_chan #(.RECOV(REC), .DELAY(DLY)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cond     (qual[i]),
      .latch_en (latch_map[i]),
      .clr      (clr_evt),
      .inhibit  (inhibit_vec[i]),
      .latched  (latched_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_off <= 1'b1;
    else        drv_off <= ~en | (|inhibit_vec);
  end

  frm_sticky #(.W(NFAULT)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (qual),
    .wipe  (err_rd | clr_evt),
    .q     (err_status)
  );

  frm_sticky #(.W(NWARN)) u_warn (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (warn_lvl),
    .wipe  (warn_rd | clr_evt),
    .q     (warn_status)
  );

  frm_diag_out #(.NF(NFAULT), .NW(NWARN)) u_diag (
    .clk        (clk),
    .rst_n      (rst_n),
    .pol        (diag_pol),
    .latch_only (diag_latch_only),
    .inhibit    (inhibit_vec),
    .latched    (latched_vec),
    .warn       (warn_lvl),
    .blank      (warn_blank),
    .pin        (diag_pin)
  );
endmodule

// File: rtl/frm_checker.sv
module frm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [7:0] fault_lvl,
  input logic [7:0] fault_mask,
  input logic       err_rd,
  input logic       diag_pol,
  input logic       diag_latch_only,
  input logic       drv_off,
  input logic [7:0] err_status,
  input logic       diag_pin,
  input logic [7:0] latch_vec
);
  // R6
  en_low_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> drv_off);

  // R2
  ov_level_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_lvl[2] && !fault_mask[2]) |=> ##1 drv_off);

  // R7
  status_only_from_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((err_status & ~$past(err_status) & ~$past(fault_lvl & ~fault_mask)) == 8'h00));

  // R8
  read_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && ((fault_lvl & ~fault_mask) == 8'h00)) |=> (err_status == 8'h00));

  // R11
  latch_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_latch_only && latch_vec == 8'h00) |=> (diag_pin == !diag_pol));
endmodule

bind fault_retry_mgr frm_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .en              (en),
  .fault_lvl       (fault_lvl),
  .fault_mask      (fault_mask),
  .err_rd          (err_rd),
  .diag_pol        (diag_pol),
  .diag_latch_only (diag_latch_only),
  .drv_off         (drv_off),
  .err_status      (err_status),
  .diag_pin        (diag_pin),
  .latch_vec       (latched_vec)
);

// File: tb/fault_retry_mgr_tb_top.sv
module fault_retry_mgr_tb_top;
  localparam int NW    = 8;
  localparam int RETRY = 20;
  localparam int LOCK  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] fault_lvl = '0, fault_mask = '0;
  logic [2:0] latch_en = '0;
  logic [NW-1:0] warn_lvl = '0, warn_blank = '0;
  logic diag_pol = 1'b0, diag_latch_only = 1'b0, low_duty_off = 1'b0;
  logic rst_wr_valid = 1'b0;
  logic [7:0] rst_wr_data = '0;
  logic err_rd = 1'b0, warn_rd = 1'b0;
  logic drv_off, diag_pin;
  logic [7:0] err_status;
  logic [NW-1:0] warn_status;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fault_retry_mgr #(.NWARN(NW), .RETRY_CYCLES(RETRY), .LOCK_CYCLES(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fault_lvl(fault_lvl), .fault_mask(fault_mask),
    .latch_en(latch_en), .warn_lvl(warn_lvl), .warn_blank(warn_blank),
    .diag_pol(diag_pol), .diag_latch_only(diag_latch_only), .low_duty_off(low_duty_off),
    .rst_wr_valid(rst_wr_valid), .rst_wr_data(rst_wr_data), .err_rd(err_rd),
    .warn_rd(warn_rd), .drv_off(drv_off), .err_status(err_status),
    .warn_status(warn_status), .diag_pin(diag_pin));

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sticky_next(input logic [7:0] cur, input logic [7:0] set,
                                              input logic wipe);
    return wipe ? set : (cur | set);
  endfunction

  // pulse one fault for one cycle, return edges until drv_off falls
  task automatic pulse_and_measure(input int bit_i, output int n);
    fault_lvl[bit_i] = 1'b1;
    tick();
    fault_lvl[bit_i] = 1'b0;
    n = 0;
    for (int k = 1; k < 500; k++) begin
      tick();
      if (!drv_off) begin n = k; break; end
    end
  endtask

  task automatic read_err();
    err_rd = 1'b1; tick(); err_rd = 1'b0; tick();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] exp_err, exp_warn, q_now, q_prev;
    void'($urandom(32'd1234));

    tick(3);
    chk("R6 reset drv_off", drv_off, 1);
    chk("R7 reset err_status", err_status, 0);
    chk("R9 reset warn_status", warn_status, 0);
    chk("R10 reset diag inactive", diag_pin, 1);

    rst_n = 1'b1; tick();
    en = 1'b1; tick(2);
    chk("R6 enabled drv_off low", drv_off, 0);

    // R1 overcurrent timed retry
    pulse_and_measure(0, n);
    chk("R1 overcurrent retry edges", n, RETRY + 1);
    chk("R7 overcurrent status bit0", err_status, 8'h01);
    read_err();
    chk("R8 read clears idle bit", err_status, 0);
    pulse_and_measure(5, n);
    chk("R1 fet short retry edges", n, RETRY + 1);
    read_err();

    // R3 locked rotor
    pulse_and_measure(7, n);
    chk("R3 lock retry edges", n, 8 * LOCK + 1);
    read_err();

    // R2 level fault
    fault_lvl[2] = 1'b1; tick(10);
    chk("R2 ov holds drv_off", drv_off, 1);
    chk("R10 diag active low pol", diag_pin, 0);
    fault_lvl[2] = 1'b0; tick();
    chk("R2 ov lag edge1", drv_off, 1);
    tick();
    chk("R2 ov released edge2", drv_off, 0);
    read_err();

    // R8 read and set in the same cycle
    fault_lvl[3] = 1'b1; err_rd = 1'b1; tick();
    err_rd = 1'b0; fault_lvl[3] = 1'b0;
    chk("R8 set wins over read", err_status, 8'h08);
    tick(3); read_err();
    chk("R8 cleared after gone", err_status, 0);

    // R7 mask
    fault_mask[4] = 1'b1; fault_lvl[4] = 1'b1; tick(4);
    chk("R7 masked no status", err_status, 0);
    chk("R7 masked no drv_off", drv_off, 0);
    fault_lvl[4] = 1'b0; fault_mask[4] = 1'b0; tick();

    // R4/R5 latch and write clear
    latch_en = 3'b001;
    pulse_and_measure(0, n);
    chk("R4 latched overcurrent holds", drv_off, 1);
    rst_wr_data = 8'h7F; rst_wr_valid = 1'b1; tick(); rst_wr_valid = 1'b0; tick(3);
    chk("R5 wrong key ignored", drv_off, 1);
    rst_wr_data = 8'hFF; rst_wr_valid = 1'b1; tick(); rst_wr_valid = 1'b0; tick();
    chk("R5 key write clears", drv_off, 0);

    latch_en = 3'b010;
    fault_lvl[5] = 1'b1; tick(); fault_lvl[5] = 1'b0; tick(50);
    chk("R4 latched short holds", drv_off, 1);
    low_duty_off = 1'b1; tick(); low_duty_off = 1'b0; tick();
    chk("R5 low duty clears", drv_off, 0);

    latch_en = 3'b100;
    fault_lvl[7] = 1'b1; tick(); fault_lvl[7] = 1'b0; tick(100);
    chk("R4 latched lock holds", drv_off, 1);
    en = 1'b0; tick(); en = 1'b1; tick();
    chk("R5 en low clears", drv_off, 0);

    latch_en = 3'b001;
    fault_lvl[0] = 1'b1; tick(); fault_lvl[0] = 1'b0; tick(30);
    chk("R4 latched before por", drv_off, 1);
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    chk("R5 por clears", drv_off, 0);

    // R11 latched-only diagnostic
    diag_latch_only = 1'b1; latch_en = 3'b000;
    fault_lvl[2] = 1'b1; tick(5);
    chk("R11 unlatched fault quiet", diag_pin, 1);
    chk("R11 status still set", err_status[2], 1);
    fault_lvl[2] = 1'b0; tick(3); read_err();
    latch_en = 3'b001;
    fault_lvl[0] = 1'b1; tick(); fault_lvl[0] = 1'b0; tick(3);
    chk("R11 latched fault drives diag", diag_pin, 0);
    rst_wr_data = 8'hFF; rst_wr_valid = 1'b1; tick(); rst_wr_valid = 1'b0; tick(3);
    chk("R11 diag quiet after clear", diag_pin, 1);
    diag_latch_only = 1'b0; latch_en = 3'b000; read_err();

    // R10 polarity
    diag_pol = 1'b1; fault_lvl[6] = 1'b1; tick(4);
    chk("R10 active high pol", diag_pin, 1);
    fault_lvl[6] = 1'b0; tick(4);
    chk("R10 inactive high pol", diag_pin, 0);
    diag_pol = 1'b0; read_err();

    // R9 warnings
    warn_lvl[3] = 1'b1; warn_blank[3] = 1'b1; tick(3);
    chk("R9 warn status set", warn_status, 8'h08);
    chk("R10 blanked warning quiet", diag_pin, 1);
    chk("R9 warning keeps motor on", drv_off, 0);
    warn_blank[3] = 1'b0; tick(2);
    chk("R10 unblanked warning active", diag_pin, 0);
    warn_lvl[3] = 1'b0; warn_rd = 1'b1; tick(); warn_rd = 1'b0; tick(2);
    chk("R9 warn read clears", warn_status, 0);
    chk("R10 diag back inactive", diag_pin, 1);
    read_err();

    // random phase: level faults, warnings, reads (R2 R8 R9)
    fault_mask = 8'hA1;
    tick(3);
    exp_err = err_status; exp_warn = warn_status; q_prev = '0;
    for (int c = 0; c < 400; c++) begin
      fault_lvl = 8'($urandom);
      warn_lvl  = NW'($urandom);
      err_rd    = ($urandom % 4) == 0;
      warn_rd   = ($urandom % 4) == 0;
      q_now     = fault_lvl & ~fault_mask;
      exp_err   = sticky_next(exp_err, q_now, err_rd);
      exp_warn  = sticky_next(exp_warn, warn_lvl, warn_rd);
      tick();
      chk("R8 random err_status", err_status, exp_err);
      chk("R9 random warn_status", warn_status, exp_warn);
      chk("R2 random drv_off", drv_off, |q_prev);
      q_prev = q_now;
    end
    fault_lvl = '0; warn_lvl = '0; err_rd = 1'b0; warn_rd = 1'b0;
    tick(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule